// File: doc/BRIEF.md
# Nested Prioritised Interrupt Controller

This block collects a parameterised set of external interrupt request lines and decides which one, if any, the processor core should service next. For every source it holds an enable bit, a sticky pending bit, an active bit and a 3-bit priority. A lower priority value is more urgent, and equal priorities go to the lower source index. Software reaches this state through a small word-addressed register port. Enable and pending each have a set register and a clear register with write-one semantics, so a single write never disturbs bits it does not name.

The most urgent source that is both enabled and pending is offered to the core through a valid/ready pair (`exc_req`/`core_ack`), together with its exception number and handler vector address. The offer stands only while that source is strictly more urgent than the running priority, which is the priority of the innermost active handler. The running priority is idle when no handler is active. On the handshake the source's pending bit clears, the source becomes active, and its priority is pushed on an internal nesting stack. An exception-return pulse pops the stack and lets the waiting sources compete again. The vector for external source k is the table base plus four times (16 + k), because the first sixteen table words belong to the core's own exceptions.

Back-pressure rules: the core may hold `core_ack` low for as long as it likes, and the pending state keeps the request alive. `exc_num` and `exc_vec` are valid only in the cycle where `exc_req` and `core_ack` are both high. Before that cycle they may change, either to a more urgent late arrival or because software cancelled the request. `core_ack` while `exc_req` is low is ignored.

Top module: `irqc_top`

## Requirements
- R1: After reset all sources are disabled and not pending, none is active, every priority reads 0, and `exc_req` is low.
- R2: A rising edge on `irq_in[k]` sets pending bit k whether or not the source is enabled. The bit stays set after the line falls. A line held high sets pending only once.
- R3: A write to word 0 sets the enable bits given by the ones in the data, and a write to word 1 clears them. Zero bits leave enables unchanged. Reads of word 0 or 1 return the enable mask.
- R4: Writes of ones to word 2 set pending bits and writes of ones to word 3 clear them. Reads of word 2 or 3 return the pending mask. Clearing a pending source before entry withdraws `exc_req` one cycle after the write, and that source is never entered.
- R5: `exc_req` is high when an enabled pending source exists whose priority is strictly lower in value than the running priority. The offered source is the one with the lowest priority value, and ties go to the lower index.
- R6: `exc_num` is 16 plus the offered source index, and `exc_vec` is `VEC_BASE + 4*exc_num`.
- R7: A cycle with `exc_req` and `core_ack` both high clears the offered source's pending bit, sets its active bit (read at word 4) and makes its priority the running priority. `core_ack` with `exc_req` low changes nothing.
- R8: While a handler runs, a pending source of equal or less urgent priority is not offered. A strictly more urgent one is offered and nests.
- R9: An `exc_ret` pulse clears the innermost active bit and restores the previous running priority, so waiting sources compete again. `exc_ret` with nothing active is ignored.
- R10: Several request pulses on one line before entry give one pending event and one entry.
- R11: Word 8+k holds the priority of source k in data bits [2:0] and reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | External request lines, rising edge sensitive |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| exc_req | output | 1 | Exception offer to the core (valid) |
| exc_num | output | 8 | Exception number of the offered source |
| exc_vec | output | 32 | Handler vector address of the offered source |
| core_ack | input | 1 | Core takes the offer (ready) |
| exc_ret | input | 1 | Core returns from the innermost handler |

## Verification
Every state change is due one clock edge after its cause: a register write, an edge on a request line, an entry handshake or a return. `exc_req`, `exc_num`, `exc_vec` and `reg_rdata` are combinational from that state. The bench therefore drives inputs at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge, where the new value must already be present. Read data is sampled shortly after the address is applied, with no clock edge in between.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int PRIO_W   = 3;
  localparam int NUM_W    = 8;
  localparam int EXT_BASE = 16;

  typedef logic [PRIO_W-1:0] prio_t;

  // register word offsets
  localparam int OFS_ENA_SET  = 0;
  localparam int OFS_ENA_CLR  = 1;
  localparam int OFS_PEND_SET = 2;
  localparam int OFS_PEND_CLR = 3;
  localparam int OFS_ACTIVE   = 4;
  localparam int OFS_PRIO     = 8;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        irq_in,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  input  logic [N_SRC-1:0]        entry_clr,
  output logic [N_SRC-1:0]        en_q,
  output logic [N_SRC-1:0]        pend_q,
  output prio_t [N_SRC-1:0]       prio_q
);
  logic [N_SRC-1:0] irq_q;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] wmask;
  logic [N_SRC-1:0] ena_set, ena_clr, pend_set, pend_clr;
  logic [N_SRC-1:0] prio_we;

  assign rise  = irq_in & ~irq_q;
  assign wmask = reg_wdata[N_SRC-1:0];

  assign ena_set  = (reg_we && reg_addr == ADDR_W'(OFS_ENA_SET))  ? wmask : '0;
  assign ena_clr  = (reg_we && reg_addr == ADDR_W'(OFS_ENA_CLR))  ? wmask : '0;
  assign pend_set = rise | ((reg_we && reg_addr == ADDR_W'(OFS_PEND_SET)) ? wmask : '0);
  assign pend_clr = entry_clr | ((reg_we && reg_addr == ADDR_W'(OFS_PEND_CLR)) ? wmask : '0);

  for (genvar k = 0; k < N_SRC; k++) begin : g_prio_we
    assign prio_we[k] = reg_we && (reg_addr == ADDR_W'(OFS_PRIO + k));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
      prio_q <= '0;
    end else begin
      irq_q  <= irq_in;
      en_q   <= (en_q | ena_set) & ~ena_clr;
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      for (int k = 0; k < N_SRC; k++)
        if (prio_we[k]) prio_q[k] <= reg_wdata[PRIO_W-1:0];
    end
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q & ~pend_clr) & ~pend_q) == '0)); // R2
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_clr & ~pend_set)) == '0)); // R4
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]  cand,
  input  prio_t [N_SRC-1:0] prio,
  output logic              any,
  output logic [IDX_W-1:0]  win_idx,
  output prio_t             win_prio
);
  // scan from the top index down; "<=" lets a lower index win ties
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!any || prio[i] <= win_prio)) begin
        any      = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqc_active_stack.sv
module irqc_active_stack
  import irqc_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int DEPTH = 2 ** PRIO_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  prio_t             push_prio,
  input  logic              pop,
  output logic [PRIO_W:0]   run_prio,
  output logic [N_SRC-1:0]  active_q
);
  localparam logic [PRIO_W:0] IDLE = (PRIO_W+1)'(DEPTH);

  logic [IDX_W-1:0] idx_stk  [DEPTH];
  prio_t            prio_stk [DEPTH];
  logic [SP_W-1:0]  sp_q, sp_mid;
  logic [PTR_W-1:0] top_ptr;
  logic             do_pop;
  logic [N_SRC-1:0] pop_mask, push_mask;

  assign top_ptr  = PTR_W'(sp_q - 1'b1);
  assign do_pop   = pop && (sp_q != '0);
  assign sp_mid   = sp_q - SP_W'(do_pop);
  assign run_prio = (sp_q == '0) ? IDLE : {1'b0, prio_stk[top_ptr]};

  always_comb begin
    pop_mask  = '0;
    push_mask = '0;
    if (do_pop) pop_mask[idx_stk[top_ptr]] = 1'b1;
    if (push)   push_mask[push_idx]        = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q     <= '0;
      active_q <= '0;
      for (int d = 0; d < DEPTH; d++) begin
        idx_stk[d]  <= '0;
        prio_stk[d] <= '0;
      end
    end else begin
      sp_q     <= sp_mid + SP_W'(push);
      active_q <= (active_q & ~pop_mask) | push_mask;
      if (push) begin
        idx_stk[PTR_W'(sp_mid)]  <= push_idx;
        prio_stk[PTR_W'(sp_mid)] <= push_prio;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (sp_mid < SP_W'(DEPTH))); // R8
  AST_PUSH_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ({1'b0, push_prio} < run_prio)); // R8
  AST_RET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && sp_q == '0) |=> (active_q == '0)); // R9
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int          N_SRC    = 8,
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] VEC_BASE = 32'h0000_0400,
  localparam int         IDX_W    = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              exc_req,
  output logic [NUM_W-1:0]  exc_num,
  output logic [31:0]       exc_vec,
  input  logic              core_ack,
  input  logic              exc_ret
);
  logic [N_SRC-1:0] en_q, pend_q, active_q, cand, entry_clr;
  prio_t [N_SRC-1:0] prio_q;
  logic              any;
  logic [IDX_W-1:0]  win_idx;
  prio_t             win_prio;
  logic [PRIO_W:0]   run_prio;
  logic              entry;

  irqc_src_bank #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .entry_clr(entry_clr), .en_q(en_q), .pend_q(pend_q), .prio_q(prio_q)
  );

  assign cand = en_q & pend_q;

  irqc_arbiter #(.N_SRC(N_SRC)) u_arb (
    .cand(cand), .prio(prio_q), .any(any), .win_idx(win_idx), .win_prio(win_prio)
  );

  irqc_active_stack #(.N_SRC(N_SRC)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(entry), .push_idx(win_idx),
    .push_prio(win_prio), .pop(exc_ret), .run_prio(run_prio), .active_q(active_q)
  );

  assign exc_req = any && ({1'b0, win_prio} < run_prio);
  assign exc_num = NUM_W'(EXT_BASE) + NUM_W'(win_idx);
  assign exc_vec = VEC_BASE + {22'd0, exc_num, 2'b00};
  assign entry   = exc_req && core_ack;

  always_comb begin
    entry_clr = '0;
    if (entry) entry_clr[win_idx] = 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_ENA_SET), ADDR_W'(OFS_ENA_CLR):   reg_rdata = DATA_W'(en_q);
      ADDR_W'(OFS_PEND_SET), ADDR_W'(OFS_PEND_CLR): reg_rdata = DATA_W'(pend_q);
      ADDR_W'(OFS_ACTIVE):                          reg_rdata = DATA_W'(active_q);
      default: begin
        for (int k = 0; k < N_SRC; k++)
          if (reg_addr == ADDR_W'(OFS_PRIO + k)) reg_rdata = DATA_W'(prio_q[k]);
      end
    endcase
  end

  AST_REQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (en_q[win_idx] && pend_q[win_idx])); // R5
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && !exc_req && !exc_ret) |=> (active_q == $past(active_q))); // R7
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int N = 8;
  localparam logic [31:0] BASE = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        exc_req;
  logic [7:0]  exc_num;
  logic [31:0] exc_vec;
  logic        core_ack = 1'b0;
  logic        exc_ret = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  irqc_top #(.N_SRC(N), .VEC_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_req(exc_req),
    .exc_num(exc_num), .exc_vec(exc_vec), .core_ack(core_ack), .exc_ret(exc_ret)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = 6'(a);
    #1 v = reg_rdata;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); irq[k] = 1'b1;
    @(negedge clk); irq[k] = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); core_ack = 1'b1;
    @(negedge clk); core_ack = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); exc_ret = 1'b1;
    @(negedge clk); exc_ret = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 exc_req", 32'(exc_req), 0);
    for (int a = 0; a < 5; a++) begin rd(a, v); chk("R1 state word", v, 0); end
    for (int k = 0; k < N; k++) begin rd(8 + k, v); chk("R1 prio", v, 0); end
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(0, 32'h05); rd(0, v); chk("R3 set", v, 32'h05);
    wr(0, 32'h02); rd(1, v); chk("R3 zeros keep", v, 32'h07);
    wr(1, 32'h04); rd(0, v); chk("R3 clear", v, 32'h03);
    wr(1, 32'hFF); rd(0, v); chk("R3 clear all", v, 0);
  endtask

  task automatic t_sticky_cancel();
    logic [31:0] v;
    pulse(3);
    rd(2, v); chk("R2 pend on disabled", v, 32'h08);
    chk("R5 no req while disabled", 32'(exc_req), 0);
    wr(0, 32'h08);
    chk("R5 req after enable", 32'(exc_req), 1);
    chk("R6 num", 32'(exc_num), 19);
    chk("R6 vec", exc_vec, BASE + 32'd76);
    wr(3, 32'h08);
    chk("R4 cancel drops req", 32'(exc_req), 0);
    rd(3, v); chk("R4 pend cleared", v, 0);
    ack(); rd(4, v); chk("R4 never entered", v, 0);
    wr(1, 32'hFF);
  endtask

  task automatic t_nesting();
    logic [31:0] v;
    wr(9, 32'h5); wr(10, 32'h2); wr(13, 32'hA);  // src5 gets 2 (bit 3 ignored)
    rd(9, v);  chk("R11 prio1", v, 5);
    rd(13, v); chk("R11 prio5", v, 2);
    wr(0, 32'hFF);
    wr(2, 32'h26);
    chk("R5 tie to low index", 32'(exc_num), 18);
    ack();
    rd(2, v); chk("R7 pend cleared", v, 32'h22);
    rd(4, v); chk("R7 active set", v, 32'h04);
    chk("R8 equal prio blocked", 32'(exc_req), 0);
    wr(8, 32'h1); wr(2, 32'h01);
    chk("R8 urgent preempts", 32'(exc_req), 1);
    chk("R8 urgent num", 32'(exc_num), 16);
    ack();
    rd(4, v); chk("R8 nested active", v, 32'h05);
    ret();
    rd(4, v); chk("R9 pop inner", v, 32'h04);
    chk("R9 still blocked", 32'(exc_req), 0);
    ret();
    rd(4, v); chk("R9 pop outer", v, 0);
    chk("R9 re-evaluate num", 32'(exc_num), 21);
    chk("R9 re-evaluate req", 32'(exc_req), 1);
    ack();
    chk("R8 less urgent blocked", 32'(exc_req), 0);
    ret();
    chk("R5 last source", 32'(exc_num), 17);
    ack(); ret();
    rd(2, v); chk("R7 all serviced", v, 0);
    wr(1, 32'hFF);
  endtask

  task automatic t_merge();
    logic [31:0] v;
    wr(0, 32'h10);
    pulse(4); pulse(4); pulse(4);
    rd(2, v); chk("R10 one pending", v, 32'h10);
    ack();
    ret();
    chk("R10 single entry", 32'(exc_req), 0);
    rd(2, v); chk("R10 pend empty", v, 0);
    @(negedge clk); irq[4] = 1'b1;
    repeat (2) @(negedge clk);
    ack();
    repeat (3) @(negedge clk);
    rd(2, v); chk("R2 held line pends once", v, 0);
    ret();
    irq[4] = 1'b0;
    ack();
    rd(4, v); chk("R7 ack without req", v, 0);
    ret();
    rd(4, v); chk("R9 ret when idle", v, 0);
    chk("R9 idle no req", 32'(exc_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_sticky_cancel();
    t_nesting();
    t_merge();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule